// File: doc/BRIEF.md
# ADC Burst and Tracking Sequencer

This block steps an analog-to-digital converter through its power, sampling and conversion phases each time a convert-start pulse arrives. It holds an 8-bit control register. The register sets three things: how long the converter needs to wake from low power, how the sample switch is driven around the start event, and how long the post-start sampling window lasts. From these settings and the two tick enables, the block drives the analog power enable, the track (sample) switch, and a single-cycle convert-go pulse. The successive-approximation engine receives that pulse, performs the conversion, and raises done when it has finished.

The burst input and the enable input together select how power is handled. With burst off, power is simply the enable bit. With burst on and enable set, the converter is held powered at all times. With burst on and enable clear, the converter rests unpowered. It wakes at each start, waits a programmed number of 400 ns time-base ticks, and drops power again after done.

Top module: `adc_burst_seq`

## Requirements
- R1: Out of reset the control register reads 0xFF, conv_go_o is low, and no sequence is in progress.
- R2: A write strobe loads the control register, which is readable on ctrl_o. The fields are: bits [7:4] power-up code, bits [3:2] tracking mode, bits [1:0] post-track code.
- R3: With burst_i low, pwr_o equals en_i in the same cycle. A start with both burst_i and en_i low is ignored and produces no conv_go_o.
- R4: With burst_i and en_i both high, pwr_o stays high during and after every sequence.
- R5: With burst_i high and en_i low, pwr_o is low at rest and rises the cycle after an accepted start. Power-up then lasts (code+1) time-base ticks, counted on clock edges after the start edge, with track_o low throughout.
- R6: In post-tracking mode (01), track_o rises once the start (or the power-up wait) completes. It stays high for N SAR ticks plus 2 clock cycles, with N = 2, 4, 8 or 16 for post-track code 00, 01, 10 or 11. conv_go_o is a one-cycle pulse in the cycle after track_o falls.
- R7: In pre-tracking mode (10), track_o is high while idle and powered. conv_go_o is high in the cycle after the start edge, or in the cycle after the power-up wait ends. track_o stays low from the start until done.
- R8: In dual-tracking mode (11), track_o is high while idle and powered, and also during the post-track window of R6.
- R9: Reserved mode 00 behaves exactly as post-tracking.
- R10: A start that arrives while a sequence is in progress is ignored: each accepted start yields exactly one conv_go_o pulse.
- R11: After conv_go_o the block waits for done_i. On the edge that samples done_i it returns to idle. In the low-power case pwr_o is low in the next cycle, and the idle track level of R7/R8 resumes.
- R12: Mode, post-track code and power-up code are captured at the accepted start. Writes to the register mid-sequence do not change that sequence's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| burst_i | input | 1 | Burst (low-power between conversions) enable |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_o | output | 8 | Control register contents |
| start_i | input | 1 | Convert-start pulse |
| sar_tick_i | input | 1 | SAR clock tick enable |
| tb_tick_i | input | 1 | 400 ns time-base tick |
| done_i | input | 1 | Conversion finished |
| pwr_o | output | 1 | Analog power enable |
| track_o | output | 1 | Track (sample) enable |
| conv_go_o | output | 1 | One-cycle convert-go pulse |

## Verification
Take ticks present on every cycle and count edges from the start edge inclusive. conv_go_o then appears after (P if low-power) + (N+2 unless pre-tracking) + 1 edges, where P is the power-up code plus one. pwr_o follows en_i in the same cycle without burst. After done_i is sampled, the idle power and track levels appear one edge later. The bench drives inputs and samples outputs on the falling edge. A per-phase model, stepped once per rising edge with the tick values just driven, predicts for each cycle whether track_o and conv_go_o must be high. The exact latency formula is checked whenever ticks are continuous.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PWRUP = 3'd1,
    ST_TRK   = 3'd2,
    ST_FIX   = 3'd3,
    ST_GO    = 3'd4,
    ST_CONV  = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    MD_RSVD = 2'b00,
    MD_POST = 2'b01,
    MD_PRE  = 2'b10,
    MD_DUAL = 2'b11
  } trk_mode_e;
endpackage

// File: rtl/adc_seq_cfg_reg.sv
module adc_seq_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/adc_seq_cnt.sv
module adc_seq_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int PWR_W   = 4,
  parameter int TK_W    = 2,
  parameter int CNT_W   = 5,
  parameter int FIX_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             burst_i,
  input  logic [PWR_W-1:0] pwr_code_i,
  input  logic [1:0]       mode_i,
  input  logic [TK_W-1:0]  tk_i,
  input  logic             sar_tick_i,
  input  logic             tb_tick_i,
  input  logic             done_i,
  input  logic             cnt_last_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             cnt_dec_o,
  output logic             busy_o,
  output logic             win_o,
  output logic             go_o
);
  seq_state_e state_q, state_d;
  logic            pre_q;
  logic [TK_W-1:0] tk_q;
  logic            accept;
  logic            pre_now;

  assign pre_now = (mode_i == MD_PRE);
  assign accept  = (state_q == ST_IDLE) && start_i && (en_i || burst_i);

  // capture the sequence settings at the accepted start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pre_q   <= 1'b0;
      tk_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        pre_q <= pre_now;
        tk_q  <= tk_i;
      end
    end
  end

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    cnt_dec_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (burst_i && !en_i) begin
          state_d    = ST_PWRUP;
          cnt_load_o = 1'b1;
          cnt_val_o  = CNT_W'(pwr_code_i) + CNT_W'(1);
        end else if (pre_now) begin
          state_d = ST_GO;
        end else begin
          state_d    = ST_TRK;
          cnt_load_o = 1'b1;
          cnt_val_o  = CNT_W'(2) << tk_i;
        end
      end
      ST_PWRUP: begin
        cnt_dec_o = tb_tick_i;
        if (tb_tick_i && cnt_last_i) begin
          if (pre_q) state_d = ST_GO;
          else begin
            state_d    = ST_TRK;
            cnt_load_o = 1'b1;
            cnt_val_o  = CNT_W'(2) << tk_q;
          end
        end
      end
      ST_TRK: begin
        cnt_dec_o = sar_tick_i;
        if (sar_tick_i && cnt_last_i) begin
          state_d    = ST_FIX;
          cnt_load_o = 1'b1;
          cnt_val_o  = CNT_W'(FIX_CYC);
        end
      end
      ST_FIX: begin
        cnt_dec_o = 1'b1;
        if (cnt_last_i) state_d = ST_GO;
      end
      ST_GO:   state_d = ST_CONV;
      ST_CONV: if (done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign win_o  = (state_q == ST_TRK) || (state_q == ST_FIX);
  assign go_o   = (state_q == ST_GO);
endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
  import adc_seq_pkg::*;
#(
  parameter int PWR_W   = 4,
  parameter int TK_W    = 2,
  parameter int FIX_CYC = 2,
  localparam int CTRL_W = PWR_W + 2 + TK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              burst_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic              start_i,
  input  logic              sar_tick_i,
  input  logic              tb_tick_i,
  input  logic              done_i,
  output logic              pwr_o,
  output logic              track_o,
  output logic              conv_go_o
);
  localparam int TRK_MAX = 2 << ((1 << TK_W) - 1);
  localparam int PWR_MAX = 1 << PWR_W;
  localparam int MAX_A   = (TRK_MAX > PWR_MAX) ? TRK_MAX : PWR_MAX;
  localparam int MAX_V   = (MAX_A > FIX_CYC) ? MAX_A : FIX_CYC;
  localparam int CNT_W   = $clog2(MAX_V + 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic [PWR_W-1:0]  pwr_code;
  logic [1:0]        mode;
  logic [TK_W-1:0]   tk;
  logic              cnt_load, cnt_dec, cnt_last;
  logic [CNT_W-1:0]  cnt_val;
  logic              busy, win, go;
  logic              idle_trk;

  adc_seq_cfg_reg #(.W(CTRL_W)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .q_o     (ctrl_q)
  );

  assign pwr_code = ctrl_q[CTRL_W-1 -: PWR_W];
  assign mode     = ctrl_q[TK_W +: 2];
  assign tk       = ctrl_q[TK_W-1:0];

  adc_seq_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .last_o     (cnt_last)
  );

  adc_seq_fsm #(
    .PWR_W   (PWR_W),
    .TK_W    (TK_W),
    .CNT_W   (CNT_W),
    .FIX_CYC (FIX_CYC)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .en_i       (en_i),
    .burst_i    (burst_i),
    .pwr_code_i (pwr_code),
    .mode_i     (mode),
    .tk_i       (tk),
    .sar_tick_i (sar_tick_i),
    .tb_tick_i  (tb_tick_i),
    .done_i     (done_i),
    .cnt_last_i (cnt_last),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .cnt_dec_o  (cnt_dec),
    .busy_o     (busy),
    .win_o      (win),
    .go_o       (go)
  );

  // idle sampling in pre and dual modes only
  assign idle_trk  = !busy && ((mode == MD_PRE) || (mode == MD_DUAL));
  assign pwr_o     = burst_i ? (en_i || busy) : en_i;
  assign track_o   = pwr_o && (idle_trk || win);
  assign conv_go_o = go;
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/adc_burst_seq_chk.sv
module adc_burst_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic burst_i,
  input logic start_i,
  input logic pwr_o,
  input logic track_o,
  input logic conv_go_o
);
  AST_GO_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_go_o |=> !conv_go_o); // R6

  AST_GO_NOT_TRACKING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_go_o |-> !track_o); // R6

  AST_NOBURST_PWR_FOLLOWS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_i |-> (pwr_o == en_i)); // R3

  AST_BURST_EN_STAYS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_i && en_i) |-> pwr_o); // R4

  AST_LP_WAKE_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_i && !en_i && $past(burst_i) && !$past(en_i) && $rose(pwr_o))
      |-> $past(start_i)); // R5
endmodule

bind adc_burst_seq adc_burst_seq_chk i_adc_burst_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .burst_i   (burst_i),
  .start_i   (start_i),
  .pwr_o     (pwr_o),
  .track_o   (track_o),
  .conv_go_o (conv_go_o)
);

// File: tb/test_adc_burst_seq.sv
module test_adc_burst_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       en_i, burst_i, ctrl_we_i, start_i, sar_tick_i, tb_tick_i, done_i;
  logic [7:0] ctrl_wdata_i, ctrl_o;
  logic       pwr_o, track_o, conv_go_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [7:0] ctrl_cur;

  adc_burst_seq i_adc_burst_seq (
    .clk_i, .rst_ni, .en_i, .burst_i, .ctrl_we_i, .ctrl_wdata_i, .ctrl_o,
    .start_i, .sar_tick_i, .tb_tick_i, .done_i, .pwr_o, .track_o, .conv_go_o
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00:   return "R9";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic bit idle_track(input logic [7:0] c, input bit pwr);
    return pwr && (c[3:2] == 2'b10 || c[3:2] == 2'b11);
  endfunction

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
    ctrl_cur  = v;
  endtask

  // one sequence; called at a falling edge with the block idle
  task automatic run_seq(input bit full, input bit mid_wr, input bit extra);
    logic [7:0] c0   = ctrl_cur;
    bit   lp   = burst_i && !en_i;
    bit   pre  = (c0[3:2] == 2'b10);
    int   p0   = int'(c0[7:4]) + 1;
    int   n0   = 2 << c0[1:0];
    int   p = p0, n = n0, f = 0, ph, lat, go_cnt = 0, go_at = -1, exp_lat;
    bit   go_bad = 0, trk_bad = 0, pwr_bad = 0, fin = 0;
    string rq = mode_req(c0[3:2]);
    bit   st, tb;
    start_i = 1'b1;
    sar_tick_i = full ? 1'b1 : 1'($urandom);
    tb_tick_i  = full ? 1'b1 : 1'($urandom);
    @(negedge clk_i);
    start_i = 1'b0;
    ph  = lp ? 0 : (pre ? 3 : 1);
    lat = 1;
    for (int k = 0; k < 3000 && !fin; k++) begin
      if (conv_go_o) begin go_cnt++; if (go_at < 0) go_at = lat; end
      if (conv_go_o !== (ph == 3)) go_bad = 1;
      if (track_o !== (ph == 1 || ph == 2)) trk_bad = 1;
      if (pwr_o !== 1'b1) pwr_bad = 1;
      st = full ? 1'b1 : 1'($urandom);
      tb = full ? 1'b1 : 1'($urandom);
      sar_tick_i = st; tb_tick_i = tb;
      start_i   = extra ? 1'($urandom) : 1'b0;
      done_i    = (ph == 4) && ($urandom % 3 == 0);
      ctrl_we_i = 1'b0;
      if (mid_wr && ph == 1 && ($urandom % 4 == 0)) begin
        ctrl_we_i = 1'b1; ctrl_wdata_i = 8'($urandom); ctrl_cur = ctrl_wdata_i;
      end
      case (ph)
        0: if (tb) begin p--; if (p == 0) begin if (pre) ph = 3; else begin ph = 1; n = n0; end end end
        1: if (st) begin n--; if (n == 0) begin ph = 2; f = 2; end end
        2: begin f--; if (f == 0) ph = 3; end
        3: ph = 4;
        default: if (done_i) fin = 1;
      endcase
      @(negedge clk_i);
      lat++;
    end
    start_i = 1'b0; done_i = 1'b0; ctrl_we_i = 1'b0;
    chk(go_cnt == 1, "R10", "conv_go pulses per start", go_cnt, 1);
    chk(!go_bad, rq, "conv_go timing", go_at, -1);
    chk(!trk_bad, rq, "track window", int'(trk_bad), 0);
    chk(!pwr_bad, lp ? "R5" : "R4", "power held in sequence", int'(pwr_bad), 0);
    if (full) begin
      exp_lat = (lp ? p0 : 0) + (pre ? 0 : n0 + 2) + 1;
      chk(go_at == exp_lat, pre ? "R7" : "R6", "latency edges", go_at, exp_lat);
    end
    if (mid_wr) chk(!go_bad && !trk_bad, "R12", "mid-sequence write ignored", int'(go_bad), 0);
    chk(pwr_o == en_i, "R11", "idle power after done", int'(pwr_o), int'(en_i));
    chk(track_o == idle_track(ctrl_cur, en_i), "R11", "idle track after done",
        int'(track_o), int'(idle_track(ctrl_cur, en_i)));
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int seen;
    void'($urandom(32'h5eed_1234));
    rst_ni = 1'b0; en_i = 0; burst_i = 0; ctrl_we_i = 0; ctrl_wdata_i = 0;
    start_i = 0; sar_tick_i = 0; tb_tick_i = 0; done_i = 0;
    repeat (3) @(negedge clk_i);
    chk(ctrl_o == 8'hFF, "R1", "reset ctrl", ctrl_o, 8'hFF);
    chk(conv_go_o == 1'b0, "R1", "reset conv_go", conv_go_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    ctrl_cur = 8'hFF;
    chk(track_o == 1'b0 && pwr_o == 1'b0, "R1", "idle unpowered outputs",
        int'({pwr_o, track_o}), 0);

    wr_ctrl(8'h5A);
    chk(ctrl_o == 8'h5A, "R2", "ctrl readback", ctrl_o, 8'h5A);

    en_i = 1'b1; #1;
    chk(pwr_o == 1'b1, "R3", "pwr follows en high", pwr_o, 1);
    en_i = 1'b0; #1;
    chk(pwr_o == 1'b0, "R3", "pwr follows en low", pwr_o, 0);

    // start with both enables low is dropped
    @(negedge clk_i);
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    seen = 0;
    repeat (30) begin if (conv_go_o) seen++; @(negedge clk_i); end
    chk(seen == 0, "R3", "ignored start", seen, 0);

    // directed corners with continuous ticks
    burst_i = 1; en_i = 0; wr_ctrl(8'hF7); run_seq(1, 0, 0);   // lp, post, longest
    burst_i = 1; en_i = 0; wr_ctrl(8'h3B); run_seq(1, 0, 0);   // lp, pre
    burst_i = 0; en_i = 1; wr_ctrl(8'h0C); run_seq(1, 0, 0);   // dual, shortest
    burst_i = 0; en_i = 1; wr_ctrl(8'h01); run_seq(1, 0, 0);   // reserved mode
    burst_i = 1; en_i = 1; wr_ctrl(8'h0B); run_seq(1, 0, 0);   // burst held powered, pre
    burst_i = 0; en_i = 1; wr_ctrl(8'h02); run_seq(1, 1, 1);   // R12 and R10

    for (int s = 0; s < 60; s++) begin
      int combo = $urandom % 3;
      burst_i = (combo != 0);
      en_i    = (combo != 1);
      wr_ctrl(8'($urandom));
      run_seq(($urandom % 4) == 0, ($urandom % 2) == 1, ($urandom % 2) == 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule